// File: doc/BRIEF.md
# Transaction Status Queue with Token-Done Handshake

This block sits between the serial interface engine of a USB device controller and the processor. Each time the engine finishes a buffer-descriptor transaction, it pushes a small status record. The record holds the endpoint number, whether the transfer was a transmit, and which of the odd/even buffers was used. Up to four records wait in order. The processor sees only the oldest one, through an 8-bit read-only status window, together with a token-done flag.

Software handles a record and then writes 1 to the token-done bit. That write retires the record, and the next waiting record takes its place. If a record is still waiting after the retire, the flag stays set, so software can handle a queued record while the engine is already finishing the next transaction.

A push that finds all four slots taken is discarded and raises a sticky overflow flag. The interrupt line is the token-done flag gated by a software enable.

Top module: `txn_status_queue`

## Requirements
- R1: After reset, `stat_byte` is 0x00 and `done_flag`, `ovf_flag` and `irq` are all 0.
- R2: While `done_flag` is 1, `stat_byte` shows the head record: bits 7:4 are the endpoint, bit 3 is the transmit bit and bit 2 is the odd-buffer bit, with bits 1:0 always 0. While `done_flag` is 0, `stat_byte` reads 0x00.
- R3: A push into an empty queue (`push_valid` high for one cycle) makes `done_flag` 1 and shows the pushed record in `stat_byte` from the cycle after the push.
- R4: Up to four records are held and shown in the order they were pushed.
- R5: A write with `flag_wr`=1 and `flag_wdata[0]`=1 while `done_flag` is 1 retires the head record. From the next cycle, `done_flag` stays 1 and the next record is shown if one remains; otherwise `done_flag` becomes 0.
- R6: A flag write with `flag_wdata[0]`=0 leaves the queue, `done_flag` and `stat_byte` unchanged. A clear issued while `done_flag` is 0 retires nothing, so a record pushed afterwards is still shown.
- R7: A push that arrives while four records are held, with no retire in the same cycle, is dropped. The stored records and their order are unchanged, and `ovf_flag` becomes 1 from the next cycle.
- R8: `ovf_flag` stays 1 until a flag write with `flag_wdata[1]`=1 clears it. If an overflow occurs in the same cycle as that clear, the flag stays 1.
- R9: A push and a token-done clear in the same cycle are both performed, even with four records held. The head leaves, the new record joins at the tail, no overflow is raised, and `done_flag` stays 1 while any record remains.
- R10: `irq` equals `done_flag` AND an enable bit, which `en_wr`/`en_wdata` write and which resets to 0. The enable does not stop `done_flag` from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Engine pushes one status record this cycle |
| push_ep | input | 4 | Endpoint number of the pushed record |
| push_tx | input | 1 | Pushed record was a transmit transaction |
| push_odd | input | 1 | Pushed record used the odd buffer |
| flag_wr | input | 1 | Write strobe for the flag clear register |
| flag_wdata | input | 2 | Write-1-to-clear data: bit 0 token-done, bit 1 overflow |
| en_wr | input | 1 | Write strobe for the interrupt enable |
| en_wdata | input | 1 | New interrupt enable value |
| stat_byte | output | 8 | Status window showing the head record |
| done_flag | output | 1 | Token-done flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The queue is exercised with a lone push and retire, with four back-to-back pushes drained in order, and with a fifth push into a full queue. These patterns separate correct ordering and pointer wrap from a lost or duplicated record, and show whether the dropped record ever appears. Pushes that coincide with a clear are tested both with one record held and with the queue full. This distinguishes a design that honours both events from one that drops the push or flags a false overflow. Clears written with bit 0 at zero, and clears issued against an empty queue, show whether a retire can happen when it should not.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef struct packed {
    logic [3:0] ep;
    logic       tx;
    logic       odd;
  } txq_entry_t;

  // Status window layout: endpoint in the high nibble, direction, buffer parity, two zero bits.
  function automatic logic [7:0] pack_status(input txq_entry_t e);
    return {e.ep, e.tx, e.odd, 2'b00};
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  txq_entry_t wr_entry,
  input  logic       rd_adv,
  output txq_entry_t head_entry
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  txq_entry_t       slots [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en)  wr_ptr <= bump(wr_ptr);
      if (rd_adv) rd_ptr <= bump(rd_ptr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (wr_en && wr_ptr == PTR_W'(g))
        slots[g] <= wr_entry;
    end
  end

  assign head_entry = slots[rd_ptr];

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             clr_done,
  input  logic             clr_ovf,
  output logic             do_write,
  output logic             do_pop,
  output logic             do_drop,
  output logic [CNT_W-1:0] count,
  output logic             done_q,
  output logic             ovf_q
);

  logic             full;
  logic [CNT_W-1:0] count_nx;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic inc, input logic dec);
    return c + CNT_W'(inc) - CNT_W'(dec);
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign do_pop   = clr_done && done_q;
  assign do_write = push_req && (!full || do_pop);
  assign do_drop  = push_req && full && !do_pop;
  assign count_nx = next_count(count, do_write, do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      count  <= count_nx;
      done_q <= (count_nx != '0);
      ovf_q  <= do_drop || (ovf_q && !clr_ovf);
    end
  end

endmodule

// File: rtl/txn_status_queue.sv
module txn_status_queue
  import txq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [3:0] push_ep,
  input  logic       push_tx,
  input  logic       push_odd,
  input  logic       flag_wr,
  input  logic [1:0] flag_wdata,
  input  logic       en_wr,
  input  logic       en_wdata,
  output logic [7:0] stat_byte,
  output logic       done_flag,
  output logic       ovf_flag,
  output logic       irq
);

  // Named internal events, observed by the bound checker.
  logic             ev_push_accept;
  logic             ev_pop;
  logic             ev_drop;
  logic [CNT_W-1:0] q_count;
  txq_entry_t       new_entry, head_entry;
  logic             irq_en_q;

  assign new_entry = '{ep: push_ep, tx: push_tx, odd: push_odd};

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_valid),
    .clr_done (flag_wr && flag_wdata[0]),
    .clr_ovf  (flag_wr && flag_wdata[1]),
    .do_write (ev_push_accept),
    .do_pop   (ev_pop),
    .do_drop  (ev_drop),
    .count    (q_count),
    .done_q   (done_flag),
    .ovf_q    (ovf_flag)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ev_push_accept),
    .wr_entry   (new_entry),
    .rd_adv     (ev_pop),
    .head_entry (head_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_en_q <= 1'b0;
    else if (en_wr) irq_en_q <= en_wdata;
  end

  assign stat_byte = done_flag ? pack_status(head_entry) : 8'h00;
  assign irq       = done_flag && irq_en_q;

endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             flag_wr,
  input logic [1:0]       flag_wdata,
  input logic [7:0]       stat_byte,
  input logic             done_flag,
  input logic             ovf_flag,
  input logic             irq,
  input logic             ev_push_accept,
  input logic             ev_pop,
  input logic             ev_drop,
  input logic [CNT_W-1:0] q_count
);

  // R2
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_flag |-> stat_byte == 8'h00);

  // R3
  first_push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push_accept && !done_flag) |=> done_flag);

  // R5
  pop_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |-> done_flag);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !(flag_wr && flag_wdata[0])) |=> ($stable(stat_byte) && $stable(done_flag)));

  // R7
  drop_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> (q_count == CNT_W'(DEPTH) && !ev_pop));

  // R7
  drop_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ($stable(stat_byte) && ovf_flag));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flag_wr && flag_wdata[1])) |=> ovf_flag);

  // R9
  push_pop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && ev_push_accept) |=> done_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

endmodule

bind txn_status_queue txq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_valid     (push_valid),
  .flag_wr        (flag_wr),
  .flag_wdata     (flag_wdata),
  .stat_byte      (stat_byte),
  .done_flag      (done_flag),
  .ovf_flag       (ovf_flag),
  .irq            (irq),
  .ev_push_accept (ev_push_accept),
  .ev_pop         (ev_pop),
  .ev_drop        (ev_drop),
  .q_count        (q_count)
);

// File: tb/tb_txn_status_queue.sv
module tb_txn_status_queue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [3:0] push_ep = '0;
  logic       push_tx = 1'b0;
  logic       push_odd = 1'b0;
  logic       flag_wr = 1'b0;
  logic [1:0] flag_wdata = '0;
  logic       en_wr = 1'b0;
  logic       en_wdata = 1'b0;
  logic [7:0] stat_byte;
  logic       done_flag, ovf_flag, irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  txn_status_queue dut (.*);

  // Expected byte, computed arithmetically: endpoint*16 + tx*8 + odd*4.
  function automatic logic [7:0] rec(input int ep, input int tx, input int odd);
    return 8'(ep * 16 + tx * 8 + odd * 4);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Inputs are driven at the falling edge; one rising edge samples them; strobes drop at the next fall.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    flag_wr    = 1'b0;
    flag_wdata = '0;
    en_wr      = 1'b0;
  endtask

  task automatic set_push(input int ep, input int tx, input int odd);
    push_valid = 1'b1;
    push_ep    = 4'(ep);
    push_tx    = 1'(tx);
    push_odd   = 1'(odd);
  endtask

  task automatic set_clr(input logic [1:0] bits);
    flag_wr    = 1'b1;
    flag_wdata = bits;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    check(req, "head byte", stat_byte, exp);
    check(req, "done before pop", done_flag, 1);
    set_clr(2'b01);
    tick();
  endtask

  task automatic t_reset();
    check("R1", "stat after reset", stat_byte, 0);
    check("R1", "done after reset", done_flag, 0);
    check("R1", "ovf after reset", ovf_flag, 0);
    check("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_single();
    set_push(5, 1, 0);
    tick();
    check("R3", "done after first push", done_flag, 1);
    check("R2", "byte layout", stat_byte, rec(5, 1, 0));
    check("R10", "irq while enable off", irq, 0);
    set_clr(2'b01);
    tick();
    check("R5", "done after last pop", done_flag, 0);
    check("R2", "window when empty", stat_byte, 0);
  endtask

  task automatic t_order();
    set_push(1, 0, 1); tick();
    set_push(2, 1, 1); tick();
    set_push(3, 0, 0); tick();
    set_push(15, 1, 1); tick();
    pop_expect("R4", rec(1, 0, 1));
    pop_expect("R4", rec(2, 1, 1));
    pop_expect("R5", rec(3, 0, 0));
    pop_expect("R4", rec(15, 1, 1));
    check("R5", "done after drain", done_flag, 0);
  endtask

  task automatic t_wzero();
    set_push(6, 0, 1); tick();
    set_clr(2'b00); tick();
    check("R6", "byte after zero write", stat_byte, rec(6, 0, 1));
    check("R6", "done after zero write", done_flag, 1);
    set_clr(2'b01); tick();
    set_clr(2'b01); tick();  // clear while flag low
    set_push(7, 1, 0); tick();
    check("R6", "push after idle clear", stat_byte, rec(7, 1, 0));
    check("R6", "done after idle clear", done_flag, 1);
    set_clr(2'b01); tick();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) begin
      set_push(8 + i, i % 2, 0); tick();
    end
    check("R7", "ovf before drop", ovf_flag, 0);
    set_push(14, 1, 1); tick();
    check("R7", "ovf after drop", ovf_flag, 1);
    check("R7", "head kept after drop", stat_byte, rec(8, 0, 0));
    for (int i = 0; i < 4; i++) pop_expect("R7", rec(8 + i, i % 2, 0));
    check("R7", "dropped record absent", done_flag, 0);
    check("R8", "ovf still set", ovf_flag, 1);
    set_clr(2'b10); tick();
    check("R8", "ovf cleared", ovf_flag, 0);
    for (int i = 0; i < 4; i++) begin
      set_push(i, 0, 0); tick();
    end
    set_push(9, 0, 0);
    set_clr(2'b10);
    tick();
    check("R8", "set wins over clear", ovf_flag, 1);
    check("R8", "done untouched by ovf clear", done_flag, 1);
    for (int i = 0; i < 4; i++) pop_expect("R8", rec(i, 0, 0));
    set_clr(2'b10); tick();
  endtask

  task automatic t_simul();
    set_push(3, 1, 0); tick();
    set_push(4, 0, 1);
    set_clr(2'b01);
    tick();
    check("R9", "done kept", done_flag, 1);
    check("R9", "new head", stat_byte, rec(4, 0, 1));
    set_clr(2'b01); tick();
    check("R9", "empty after pop", done_flag, 0);
    for (int i = 0; i < 4; i++) begin
      set_push(10 + i, 1, i % 2); tick();
    end
    set_push(2, 0, 1);
    set_clr(2'b01);
    tick();
    check("R9", "no ovf on push+pop full", ovf_flag, 0);
    for (int i = 1; i < 4; i++) pop_expect("R9", rec(10 + i, 1, i % 2));
    pop_expect("R9", rec(2, 0, 1));
    check("R9", "drained", done_flag, 0);
  endtask

  task automatic t_irq();
    en_wr = 1'b1; en_wdata = 1'b1; tick();
    check("R10", "irq idle", irq, 0);
    set_push(1, 1, 1); tick();
    check("R10", "irq on", irq, 1);
    en_wr = 1'b1; en_wdata = 1'b0; tick();
    check("R10", "irq masked", irq, 0);
    check("R10", "flag kept when masked", done_flag, 1);
    en_wr = 1'b1; en_wdata = 1'b1; tick();
    check("R10", "irq back on", irq, 1);
    set_clr(2'b01); tick();
    check("R10", "irq after pop", irq, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_wzero();
    t_overflow();
    t_simul();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule